// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver

This block is the receive path of a clock-synchronous serial port. As clock master it divides the system clock down to a serial clock, drives it out, and samples the serial data line against that clock. As clock slave it takes a clock from outside, passes it through a two-flop synchroniser, detects its edges and samples the data line at the selected edges. Bits are gathered LSB first into frames of 8 to 16 bits. Each completed frame is placed right-aligned in a 16-bit data register, with the unused upper bits at 0.

Software controls it through a small register port with three addresses. Address 0 is the received data, address 1 holds the status flags and address 2 holds the control word. In master mode a read of the data register, even a dummy one, starts the serial clock. Frames then follow back to back. A stop request that is set while a frame is in progress makes that frame the last one. A frame that completes while the previous frame has not been read is an overrun. An overrun freezes reception until software clears it. One interrupt line reports unread data and overrun, gated by a single enable bit.

Top module: `sync_rx_unit`

## Requirements
- R1: After reset the data register reads 0, the status reads 0, the control word reads 0x0800, `irq` and `sck_oe` are 0 and `sck_out` is 1.
- R2: Control bits [11:8] are the length code. Codes 8 to 15 select that many bits per frame, code 0 selects 16 bits and codes 1 to 7 select 8 bits. The code reads back as written. Bits arrive LSB first and the frame is right-aligned in the data register with the upper bits at 0.
- R3: Control bit 0 is receive enable and bit 3 selects master mode, and `sck_oe` equals the AND of the two. In master mode, a read of address 0 while enabled and with no overrun starts the serial clock, whose half period is DIV/2 system clocks. Frames then follow back to back without further reads.
- R4: When a frame completes with status bit 0 (data full) at 0, the frame is written into the data register (address 0) and data full is set to 1.
- R5: Control bit 1 is the interrupt enable, and `irq` is 1 exactly when this bit is 1 and data full or overrun is 1.
- R6: A read of address 0 clears data full. The overrun flag is left unchanged.
- R7: Control bit 2 is the stop request, and it is sampled when a frame completes. If it is 1, the master finishes that frame, returns `sck_out` to idle and keeps it idle. A later read of address 0 with receive enable at 0 does not start the clock again.
- R8: A frame that completes while data full is 1 sets status bit 1 (overrun). In that case the data register keeps its old value and the master clock stops. While overrun is 1, a read of address 0 starts no clock. A write to address 1 with bit 1 at 0 clears overrun, and reception can then be started again.
- R9: Control bit 4 is clock polarity: 0 idles the clock high and 1 idles it low. Control bit 5 is clock phase: 0 samples on the even-numbered edges of a frame (the 2nd, 4th, ...) and 1 samples on the odd-numbered edges.
- R10: With control bit 3 at 0 the block is a clock slave. It leaves `sck_oe` at 0 and samples `sdi` at the edges of `sck_in` chosen by polarity and phase, after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle; read side effects act at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sck_in | input | 1 | Serial clock from an external master (slave mode) |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock driven in master mode; idle level otherwise |
| sck_oe | output | 1 | Output enable for `sck_out` |
| irq | output | 1 | Receive interrupt request (data full or overrun) |

## Verification
A bit counter that has slipped shows up at the data port on the very next frame. The word read back is then shifted or mixed with bits of the following word, and the scoreboard compares every frame against the word the bench device sent. A run-control flag stuck at 1 keeps `sck_out` toggling after a stop frame or an overrun. Edges are counted in a 100-cycle window that opens about 20 cycles after the frame completes, so this shows within about 120 cycles. A wrong flag update changes `irq` or the status word within one cycle of the completing frame or of the clearing read or write.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DATA_W) + 1;
    localparam int IDX_W  = $clog2(DATA_W);

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    typedef struct packed {
        logic [3:0] len_code;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       stop_req;
        logic       irq_en;
        logic       rx_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{len_code: 4'b1000, default: 1'b0};

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] word;
    } frame_t;

    function automatic logic [CNT_W-1:0] frame_bits(input logic [3:0] code);
        if (code == 4'd0)
            return CNT_W'(DATA_W);
        else if (code < 4'd8)
            return CNT_W'(8);
        else
            return CNT_W'(code);
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.len_code = w[11:8];
        c.cpha     = w[5];
        c.cpol     = w[4];
        c.master   = w[3];
        c.stop_req = w[2];
        c.irq_en   = w[1];
        c.rx_en    = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_encode(input ctrl_t c);
        return {4'b0, c.len_code, 2'b0, c.cpha, c.cpol, c.master,
                c.stop_req, c.irq_en, c.rx_en};
    endfunction

endpackage

// File: rtl/srx_sck_unit.sv
`timescale 1ns/1ps
module srx_sck_unit #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic run,
    input  logic cpol,
    input  logic cpha,
    input  logic sck_in,
    input  logic sdi,
    output logic sck_out,
    output logic smp,
    output logic smp_bit
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic          smp_m_q;
    logic          smp_s_q;
    logic [2:0]    sck_sy_q;
    logic [1:0]    sdi_sy_q;

    // master clock: act_q = 1 while the clock sits away from its idle level
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            act_q   <= 1'b0;
            smp_m_q <= 1'b0;
        end else begin
            smp_m_q <= 1'b0;
            if (!master) begin
                cnt_q <= '0;
                act_q <= 1'b0;
            end else if (!run && !act_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q   <= '0;
                act_q   <= ~act_q;
                smp_m_q <= act_q ? ~cpha : cpha;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // slave clock: two-flop synchroniser plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy_q <= '0;
            sdi_sy_q <= '0;
            smp_s_q  <= 1'b0;
        end else begin
            sck_sy_q <= {sck_sy_q[1:0], sck_in};
            sdi_sy_q <= {sdi_sy_q[0], sdi};
            smp_s_q  <= (sck_sy_q[2] != sck_sy_q[1]) &&
                        ((sck_sy_q[2] == ~cpol) ? cpha : ~cpha);
        end
    end

    assign sck_out = act_q ? cpol : ~cpol;
    assign smp     = master ? smp_m_q : smp_s_q;
    assign smp_bit = master ? sdi : sdi_sy_q[1];

    a_r7_gen_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (!run && !act_q) |=> !act_q);

endmodule

// File: rtl/srx_shifter.sv
`timescale 1ns/1ps
module srx_shifter
    import srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp,
    input  logic             bit_in,
    input  logic [CNT_W-1:0] nbits,
    output frame_t           frame
);
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_nxt;
    frame_t            frame_q;

    always_comb begin
        acc_nxt = acc_q;
        acc_nxt[cnt_q[IDX_W-1:0]] = bit_in;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            frame_q <= '0;
        end else begin
            frame_q.valid <= 1'b0;
            if (smp) begin
                if (cnt_q == nbits - 1'b1) begin
                    frame_q.valid <= 1'b1;
                    frame_q.word  <= acc_nxt;
                    acc_q         <= '0;
                    cnt_q         <= '0;
                end else begin
                    acc_q <= acc_nxt;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign frame = frame_q;

    a_r4_frame_after_sample: assert property (@(posedge clk) disable iff (rst)
        frame_q.valid |-> $past(smp));

endmodule

// File: rtl/sync_rx_unit.sv
`timescale 1ns/1ps
module sync_rx_unit
    import srx_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        sck_in,
    input  logic        sdi,
    output logic        sck_out,
    output logic        sck_oe,
    output logic        irq
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] data_q;
    logic              full_q;
    logic              ovr_q;
    logic              running_q;
    logic              smp;
    logic              smp_bit;
    logic              shift_clr;
    frame_t            fr;

    wire rd_data  = bus_rd && (bus_addr == A_DATA);
    wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wire wr_stat  = bus_wr && (bus_addr == A_STAT);
    wire overrun  = fr.valid && full_q && !rd_data;

    srx_sck_unit #(.DIV(DIV)) u_sck (
        .clk     (clk),
        .rst     (rst),
        .master  (ctrl_q.master),
        .run     (running_q),
        .cpol    (ctrl_q.cpol),
        .cpha    (ctrl_q.cpha),
        .sck_in  (sck_in),
        .sdi     (sdi),
        .sck_out (sck_out),
        .smp     (smp),
        .smp_bit (smp_bit)
    );

    assign shift_clr = !ctrl_q.rx_en || ovr_q || (ctrl_q.master && !running_q);

    srx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (shift_clr),
        .smp    (smp),
        .bit_in (smp_bit),
        .nbits  (frame_bits(ctrl_q.len_code)),
        .frame  (fr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RST;
            data_q    <= '0;
            full_q    <= 1'b0;
            ovr_q     <= 1'b0;
            running_q <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_decode(bus_wdata);
            if (wr_stat && !bus_wdata[1])
                ovr_q <= 1'b0;
            if (rd_data)
                full_q <= 1'b0;
            if (overrun) begin
                ovr_q <= 1'b1;
            end else if (fr.valid) begin
                data_q <= fr.word;
                full_q <= 1'b1;
            end

            if (!ctrl_q.rx_en || !ctrl_q.master || ovr_q)
                running_q <= 1'b0;
            else if (fr.valid && (ctrl_q.stop_req || overrun))
                running_q <= 1'b0;
            else if (rd_data)
                running_q <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = data_q;
            A_STAT:  bus_rdata = {14'b0, ovr_q, full_q};
            A_CTRL:  bus_rdata = ctrl_encode(ctrl_q);
            default: bus_rdata = '0;
        endcase
    end

    assign sck_oe = ctrl_q.master && ctrl_q.rx_en;
    assign irq    = ctrl_q.irq_en && (full_q || ovr_q);

    a_r6_read_clears_full: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !fr.valid) |=> !full_q);

    a_r8_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
        overrun |=> (ovr_q && $stable(data_q)));

    a_r7_stop_ends_run: assert property (@(posedge clk) disable iff (rst)
        (fr.valid && ctrl_q.stop_req) |=> !running_q);

    a_r5_irq_on_new_frame: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.irq_en && fr.valid && !full_q && !wr_ctrl) |=> irq);

endmodule

// File: tb/sync_rx_unit_tb.sv
`timescale 1ns/1ps
module sync_rx_unit_tb;

    localparam int DIVB = 8;
    localparam logic [15:0] RXEN = 16'h0001, IRQE = 16'h0002, STOP = 16'h0004,
                            MSTR = 16'h0008, CPOL = 16'h0010, CPHA = 16'h0020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck_in = 1'b1;
    logic        sdi_w;
    logic        sck_out;
    logic        sck_oe;
    logic        irq;

    logic        use_dev = 1'b0;
    logic        sdi_dev = 1'b0;
    logic        sdi_slv = 1'b0;
    assign sdi_w = use_dev ? sdi_dev : sdi_slv;

    int nchk = 0;
    int nfail = 0;
    int edges = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    // bench serial device for master mode
    logic [15:0] dev_w [8];
    int  arm_cnt = 0;
    int  seen_arm = 0;
    bit  dev_on = 0;
    bit  b_cpol = 0, b_cpha = 0;
    int  b_len = 8;
    int  bi = 0, widx = 0;

    always #10 clk = ~clk;

    sync_rx_unit #(.DIV(DIVB)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_in(sck_in), .sdi(sdi_w), .sck_out(sck_out), .sck_oe(sck_oe),
        .irq(irq)
    );

    always @(sck_out) edges++;

    always @(sck_out or arm_cnt) begin
        if (arm_cnt != seen_arm) begin
            seen_arm = arm_cnt;
            bi = 0;
            widx = 0;
            sdi_dev = dev_w[0][0];
        end else if (dev_on && ((sck_out == b_cpol) ? b_cpha : !b_cpha)) begin
            @(posedge clk);
            #1;
            bi++;
            if (bi >= b_len) begin
                bi = 0;
                widx++;
            end
            sdi_dev = (widx < 8) ? dev_w[widx][bi] : 1'b0;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] lmask(input int len);
        return (len >= 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
    endfunction

    // driver side: load a word for the device and the scoreboard
    task automatic load(input int i, input logic [15:0] w, input int len);
        dev_w[i] = w;
        exp_q.push_back(w & lmask(len));
    endtask

    task automatic arm(input bit cp, input bit ph, input int len);
        b_cpol = cp; b_cpha = ph; b_len = len;
        use_dev = 1'b1;
        arm_cnt++;
        #1 dev_on = 1'b1;
    endtask

    task automatic wait_irq();
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) chk("R5 irq never raised", 0, 1);
    endtask

    // monitor side: pop and compare each frame as the design delivers it
    task automatic drain(input int n, input bit stop_last, input logic [15:0] cval);
        logic [15:0] v;
        int e0;
        for (int k = 0; k < n; k++) begin
            bit last = stop_last && (k == n - 1);
            if (last) wr(2'd2, cval | STOP);
            wait_irq();
            if (last) begin
                repeat (20) @(negedge clk);
                e0 = edges;
                repeat (100) @(negedge clk);
                chk("R7 clock halted after stop frame", edges - e0, 0);
                wr(2'd2, cval & ~(RXEN | STOP));
            end
            rd(2'd0, v);
            if (exp_q.size() == 0) chk("R4 unexpected frame", v, 16'hDEAD);
            else chk("R4 received frame", v, exp_q.pop_front());
            if (last) begin
                e0 = edges;
                repeat (100) @(negedge clk);
                chk("R7 read with receive disabled restarts nothing", edges - e0, 0);
            end
        end
        dev_on = 1'b0;
    endtask

    task automatic slave_frame(input logic [15:0] w, input int nb, input bit cp);
        for (int i = 0; i < nb; i++) begin
            sdi_slv = w[i];
            repeat (6) @(negedge clk);
            sck_in = cp;
            repeat (6) @(negedge clk);
            sck_in = ~cp;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        longint t1, t2;
        int e0, t;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 data after reset", v, 16'h0000);
        rd(2'd1, v); chk("R1 status after reset", v, 16'h0000);
        rd(2'd2, v); chk("R1 control after reset", v, 16'h0800);
        chk("R1 irq after reset", irq, 0);
        chk("R1 sck_oe after reset", sck_oe, 0);
        chk("R1 sck_out idles high after reset", sck_out, 1);

        // master, polarity 0 phase 0, 8 bits, three frames then stop
        wr(2'd2, 16'h0800 | MSTR | IRQE | RXEN);
        chk("R3 sck_oe in enabled master mode", sck_oe, 1);
        chk("R9 polarity 0 idles high", sck_out, 1);
        load(0, 16'h00A5, 8); load(1, 16'h003C, 8); load(2, 16'h01F0, 8);
        arm(0, 0, 8);
        rd(2'd0, v);
        @(sck_out); t1 = $time;
        @(sck_out); t2 = $time;
        chk("R3 half period of serial clock", 32'(t2 - t1), 32'(DIVB / 2 * 20));
        drain(3, 1, 16'h0800 | MSTR | IRQE | RXEN);

        // master, polarity 1 phase 1, 12 bits
        wr(2'd2, 16'h0C00 | CPHA | CPOL | MSTR | IRQE | RXEN);
        chk("R9 polarity 1 idles low", sck_out, 0);
        load(0, 16'hFABC, 12); load(1, 16'h05A5, 12);
        arm(1, 1, 12);
        rd(2'd0, v);
        drain(2, 1, 16'h0C00 | CPHA | CPOL | MSTR | IRQE | RXEN);

        // master, code 0 gives 16 bits, polarity 0 phase 1
        wr(2'd2, CPHA | MSTR | IRQE | RXEN);
        rd(2'd2, v); chk("R2 length code 0 reads back", v, 16'h002B);
        load(0, 16'h8001, 16); load(1, 16'h7FFE, 16);
        arm(0, 1, 16);
        rd(2'd0, v);
        drain(2, 1, CPHA | MSTR | IRQE | RXEN);

        // overrun with interrupt disabled
        wr(2'd2, 16'h0800 | MSTR | RXEN);
        dev_w[0] = 16'h0011; dev_w[1] = 16'h0022; dev_w[2] = 16'h0033;
        arm(0, 0, 8);
        rd(2'd0, v);
        t = 0;
        do begin rd(2'd1, v); t++; end while (!v[0] && t < 2000);
        chk("R4 data full after first frame", v[0], 1);
        chk("R5 irq gated off while full", irq, 0);
        t = 0;
        do begin rd(2'd1, v); t++; end while (!v[1] && t < 2000);
        chk("R8 status shows full and overrun", v, 16'h0003);
        rd(2'd0, v); chk("R8 data keeps first frame", v, 16'h0011);
        repeat (20) @(negedge clk);
        e0 = edges;
        repeat (100) @(negedge clk);
        chk("R8 clock stopped on overrun", edges - e0, 0);
        rd(2'd1, v); chk("R6 read clears full, overrun held", v, 16'h0002);
        e0 = edges;
        rd(2'd0, v);
        repeat (100) @(negedge clk);
        chk("R8 read during overrun starts nothing", edges - e0, 0);
        dev_on = 1'b0;
        wr(2'd2, 16'h0800 | MSTR | IRQE | RXEN);
        chk("R5 irq from overrun when enabled", irq, 1);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk("R8 overrun cleared by status write", v, 16'h0000);
        chk("R5 irq low after clear", irq, 0);
        load(0, 16'h005A, 8); load(1, 16'h00C3, 8);
        arm(0, 0, 8);
        rd(2'd0, v);
        drain(2, 1, 16'h0800 | MSTR | IRQE | RXEN);

        // slave, polarity 0 phase 0, code 3 behaves as 8 bits
        use_dev = 1'b0;
        sck_in = 1'b1;
        wr(2'd2, 16'h0300 | IRQE | RXEN);
        chk("R10 sck_oe low in slave mode", sck_oe, 0);
        rd(2'd2, v); chk("R2 length code 3 reads back", v, 16'h0303);
        exp_q.push_back(16'h005C);
        slave_frame(16'h015C, 8, 0);
        drain(1, 0, 16'h0);
        exp_q.push_back(16'h00A3);
        slave_frame(16'h00A3, 8, 0);
        drain(1, 0, 16'h0);

        // slave, polarity 1 phase 1, 9 bits
        wr(2'd2, 16'h0900 | CPHA | CPOL | IRQE);
        sck_in = 1'b0;
        repeat (10) @(negedge clk);
        wr(2'd2, 16'h0900 | CPHA | CPOL | IRQE | RXEN);
        exp_q.push_back(16'h01A5);
        slave_frame(16'h01A5, 9, 1);
        drain(1, 0, 16'h0);
        chk("R4 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule